// File: doc/BRIEF.md
# Interrupt Pending and Selection Unit

This block keeps one pending flag and one enable flag for each of twelve interrupt codes. Hardware sources raise or drop pending flags through numbered strobes. Software can replace either vector wholesale through a simple write port, and it can read both vectors back at any time.

Three global enable inputs, one per privilege level, gate whole groups of codes. The block combines pending, enable and the global mask. It then reports, from registers, whether an interrupt can be taken, the code chosen, and a cause word ready for a trap handler. When more than one code qualifies, the lowest code is chosen.

Trap entry, delegation and instruction decode are handled elsewhere. The core samples the registered request and cause when it is ready to take a trap.

Top module: `irq_select_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, both stored vectors read zero, `irq_req` is 0, `irq_code` is 0 and `irq_cause` is 0.
- R2: `post_vld` sets the pending bit numbered `post_num`. `clr_vld` clears the bit numbered `clr_num`. `clr_all` clears every pending bit. None of the three changes the enable vector.
- R3: When a post and a clear (single or all) hit the same pending bit in one cycle, the bit ends set. A software pending write in that cycle overrides both, and the bit takes the written value.
- R4: A write strobe (`pend_we` or `en_we`) replaces the stored vector with the write data from the next clock edge. `pend_rdata` and `en_rdata` always return the stored vectors.
- R5: Bits 2, 6 and 10 of both vectors always read 0, whatever is written or posted. Posts and clears with a number of 12 or more change nothing.
- R6: `gie_m` unmasks codes 3, 7 and 11. `gie_s` unmasks codes 1, 5 and 9. `gie_u` unmasks codes 0, 4 and 8.
- R7: `irq_req` is 1 exactly when at least one code is pending, enabled and globally unmasked.
- R8: `irq_code` is the lowest code that is pending, enabled and unmasked. It is 0 when there is no request.
- R9: `irq_cause` is 32 bits wide. With a request, bit 31 is 1, bits 3:0 hold the code and every other bit is 0. Without a request it is all zero.
- R10: The outputs are registered. Strobes, writes and global enables applied before a clock edge are reflected in `irq_req`, `irq_code` and `irq_cause` right after that same edge.

Bit positions match the code numbering: bit n of either vector belongs to code n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_vld | input | 1 | Raise the pending bit given by post_num |
| post_num | input | 4 | Code number to raise |
| clr_vld | input | 1 | Drop the pending bit given by clr_num |
| clr_num | input | 4 | Code number to drop |
| clr_all | input | 1 | Drop all pending bits |
| pend_we | input | 1 | Software write of the pending vector |
| pend_wdata | input | 12 | Pending write data |
| pend_rdata | output | 12 | Stored pending vector |
| en_we | input | 1 | Software write of the enable vector |
| en_wdata | input | 12 | Enable write data |
| en_rdata | output | 12 | Stored enable vector |
| gie_m | input | 1 | Machine-level global enable |
| gie_s | input | 1 | Supervisor-level global enable |
| gie_u | input | 1 | User-level global enable |
| irq_req | output | 1 | An interrupt can be taken |
| irq_code | output | 4 | Selected code |
| irq_cause | output | 32 | Cause word with the interrupt flag in bit 31 |

## Verification
Hardware strobes and software writes can both target the pending vector in the same cycle, and a post can coincide with a clear or clear-all on the same bit. The bench drives these collisions directly. It also lets random stimulus assert all strobes together with random numbers and write data. A bench model gives software writes first priority, then posts, then clears. It predicts the stored vector and the registered selection after each edge, so any swap of precedence shows up in the read-back value or in the selected code.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_SUPV = 2'd1,
    LVL_RSVD = 2'd2,
    LVL_MACH = 2'd3
  } irq_level_e;

  localparam int LVL_STRIDE = 4;

  // Bit n set when code n belongs to the given privilege level.
  function automatic logic [63:0] level_mask(irq_level_e lvl, int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      if ((i % LVL_STRIDE) == int'(lvl)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Bit n set when code n has storage (not a reserved slot).
  function automatic logic [63:0] impl_mask(int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < n; i++) begin
      if ((i % LVL_STRIDE) != int'(LVL_RSVD)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int NUM_SRC = 12,
  parameter int CW      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [CW-1:0]      post_num,
  input  logic               clr_vld,
  input  logic [CW-1:0]      clr_num,
  input  logic               clr_all,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_d
);
  localparam logic [NUM_SRC-1:0] IMPL = NUM_SRC'(irq_sel_pkg::impl_mask(NUM_SRC));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      logic set_hit, clr_hit;
      assign set_hit = post_vld && (post_num == CW'(i));
      assign clr_hit = clr_all || (clr_vld && (clr_num == CW'(i)));
      always_comb begin
        if (we)           pend_d[i] = wdata[i];
        else if (set_hit) pend_d[i] = 1'b1;
        else if (clr_hit) pend_d[i] = 1'b0;
        else              pend_d[i] = pend_q[i];
      end
    end else begin : g_rsvd
      assign pend_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_enable_store.sv
module irq_enable_store #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d
);
  localparam logic [NUM_SRC-1:0] IMPL = NUM_SRC'(irq_sel_pkg::impl_mask(NUM_SRC));

  assign en_d = we ? (wdata & IMPL) : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/irq_global_mask.sv
module irq_global_mask #(
  parameter int NUM_SRC = 12
) (
  input  logic               gie_m,
  input  logic               gie_s,
  input  logic               gie_u,
  output logic [NUM_SRC-1:0] gmask
);
  import irq_sel_pkg::*;
  localparam logic [NUM_SRC-1:0] M_GRP = NUM_SRC'(level_mask(LVL_MACH, NUM_SRC));
  localparam logic [NUM_SRC-1:0] S_GRP = NUM_SRC'(level_mask(LVL_SUPV, NUM_SRC));
  localparam logic [NUM_SRC-1:0] U_GRP = NUM_SRC'(level_mask(LVL_USER, NUM_SRC));

  assign gmask = ({NUM_SRC{gie_m}} & M_GRP)
               | ({NUM_SRC{gie_s}} & S_GRP)
               | ({NUM_SRC{gie_u}} & U_GRP);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_SRC = 12,
  parameter int CW      = 4
) (
  input  logic [NUM_SRC-1:0] vec,
  output logic               hit,
  output logic [CW-1:0]      idx
);
  assign hit = |vec;

  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit #(
  parameter int NUM_SRC = 12,
  parameter int XLEN    = 32,
  parameter int CW      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post_vld,
  input  logic [CW-1:0]      post_num,
  input  logic               clr_vld,
  input  logic [CW-1:0]      clr_num,
  input  logic               clr_all,
  input  logic               pend_we,
  input  logic [NUM_SRC-1:0] pend_wdata,
  output logic [NUM_SRC-1:0] pend_rdata,
  input  logic               en_we,
  input  logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] en_rdata,
  input  logic               gie_m,
  input  logic               gie_s,
  input  logic               gie_u,
  output logic               irq_req,
  output logic [CW-1:0]      irq_code,
  output logic [XLEN-1:0]    irq_cause
);
  logic [NUM_SRC-1:0] pend_nx, en_nx, gmask, ready;
  logic               pick_hit;
  logic [CW-1:0]      pick_idx;
  logic [XLEN-1:0]    cause_nx;

  irq_pend_store #(.NUM_SRC(NUM_SRC), .CW(CW)) u_pend (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_num(post_num),
    .clr_vld(clr_vld), .clr_num(clr_num), .clr_all(clr_all),
    .we(pend_we), .wdata(pend_wdata),
    .pend_q(pend_rdata), .pend_d(pend_nx)
  );

  irq_enable_store #(.NUM_SRC(NUM_SRC)) u_en (
    .clk(clk), .rst(rst),
    .we(en_we), .wdata(en_wdata),
    .en_q(en_rdata), .en_d(en_nx)
  );

  irq_global_mask #(.NUM_SRC(NUM_SRC)) u_gmask (
    .gie_m(gie_m), .gie_s(gie_s), .gie_u(gie_u), .gmask(gmask)
  );

  // Selection looks at next-state vectors so outputs track inputs one edge later.
  assign ready = pend_nx & en_nx & gmask;

  irq_lowest_pick #(.NUM_SRC(NUM_SRC), .CW(CW)) u_pick (
    .vec(ready), .hit(pick_hit), .idx(pick_idx)
  );

  always_comb begin
    cause_nx = '0;
    if (pick_hit) begin
      cause_nx[CW-1:0] = pick_idx;
      cause_nx[XLEN-1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_code  <= '0;
      irq_cause <= '0;
    end else begin
      irq_req   <= pick_hit;
      irq_code  <= pick_hit ? pick_idx : '0;
      irq_cause <= cause_nx;
    end
  end
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int NUM_SRC = 12,
  parameter int XLEN    = 32,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               post_vld,
  input logic [CW-1:0]      post_num,
  input logic               clr_vld,
  input logic               clr_all,
  input logic               pend_we,
  input logic [NUM_SRC-1:0] pend_wdata,
  input logic [NUM_SRC-1:0] pend_rdata,
  input logic               en_we,
  input logic [NUM_SRC-1:0] en_wdata,
  input logic [NUM_SRC-1:0] en_rdata,
  input logic               gie_m,
  input logic               gie_s,
  input logic               gie_u,
  input logic               irq_req,
  input logic [CW-1:0]      irq_code,
  input logic [XLEN-1:0]    irq_cause
);
  import irq_sel_pkg::*;
  localparam logic [NUM_SRC-1:0] IMPL  = NUM_SRC'(impl_mask(NUM_SRC));
  localparam logic [NUM_SRC-1:0] M_GRP = NUM_SRC'(level_mask(LVL_MACH, NUM_SRC));
  localparam logic [NUM_SRC-1:0] S_GRP = NUM_SRC'(level_mask(LVL_SUPV, NUM_SRC));
  localparam logic [NUM_SRC-1:0] U_GRP = NUM_SRC'(level_mask(LVL_USER, NUM_SRC));

  logic [2:0]         gie_q;
  logic [NUM_SRC-1:0] gm_prev, live, below, code_bit;

  always_ff @(posedge clk) gie_q <= {gie_m, gie_s, gie_u};

  always_comb begin
    gm_prev  = ({NUM_SRC{gie_q[2]}} & M_GRP) | ({NUM_SRC{gie_q[1]}} & S_GRP)
             | ({NUM_SRC{gie_q[0]}} & U_GRP);
    live     = pend_rdata & en_rdata & gm_prev;
    code_bit = NUM_SRC'(1) << irq_code;
    below    = code_bit - NUM_SRC'(1);
  end

  p_cause_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_cause[XLEN-1] && irq_cause[CW-1:0] == irq_code));
  p_idle_cause_r9: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_cause == '0 && irq_code == '0));
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ((pend_rdata | en_rdata) & ~IMPL) == '0);
  p_post_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (post_vld && !pend_we && int'(post_num) < NUM_SRC && IMPL[post_num])
      |=> pend_rdata[$past(post_num)]);
  p_clrall_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !post_vld && !pend_we) |=> pend_rdata == '0);
  p_en_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(en_rdata));
  p_wr_pend_r4: assert property (@(posedge clk) disable iff (rst)
    pend_we |=> pend_rdata == ($past(pend_wdata) & IMPL));
  p_wr_en_r4: assert property (@(posedge clk) disable iff (rst)
    en_we |=> en_rdata == ($past(en_wdata) & IMPL));
  p_req_match_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req == (live != '0));
  p_sel_live_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((live & code_bit) != '0));
  p_lowest_r8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((live & below) == '0));
  // Unused input kept for a uniform bind.
  logic unused_ok;
  assign unused_ok = clr_vld;
endmodule

bind irq_select_unit irq_select_chk #(.NUM_SRC(NUM_SRC), .XLEN(XLEN), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_num(post_num),
  .clr_vld(clr_vld), .clr_all(clr_all), .pend_we(pend_we),
  .pend_wdata(pend_wdata), .pend_rdata(pend_rdata), .en_we(en_we),
  .en_wdata(en_wdata), .en_rdata(en_rdata), .gie_m(gie_m), .gie_s(gie_s),
  .gie_u(gie_u), .irq_req(irq_req), .irq_code(irq_code), .irq_cause(irq_cause)
);

// File: tb/irq_select_unit_tb.sv
`timescale 1ns/1ps
module irq_select_unit_tb;
  localparam logic [11:0] IMPL = 12'hBBB;
  localparam logic [11:0] M_G  = 12'h888;
  localparam logic [11:0] S_G  = 12'h222;
  localparam logic [11:0] U_G  = 12'h111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic post_vld = 0, clr_vld = 0, clr_all = 0, pend_we = 0, en_we = 0;
  logic [3:0] post_num = 0, clr_num = 0;
  logic [11:0] pend_wdata = 0, en_wdata = 0;
  logic gie_m = 0, gie_s = 0, gie_u = 0;
  logic [11:0] pend_rdata, en_rdata;
  logic irq_req;
  logic [3:0] irq_code;
  logic [31:0] irq_cause;

  logic [11:0] m_pend = 0, m_en = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_select_unit u_dut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_num(post_num),
    .clr_vld(clr_vld), .clr_num(clr_num), .clr_all(clr_all),
    .pend_we(pend_we), .pend_wdata(pend_wdata), .pend_rdata(pend_rdata),
    .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
    .gie_m(gie_m), .gie_s(gie_s), .gie_u(gie_u),
    .irq_req(irq_req), .irq_code(irq_code), .irq_cause(irq_cause)
  );

  function automatic logic [11:0] nxt_pend(logic [11:0] q);
    logic [11:0] d;
    for (int i = 0; i < 12; i++) begin
      if (pend_we) d[i] = pend_wdata[i];
      else if (post_vld && post_num == 4'(i)) d[i] = 1'b1;
      else if (clr_all || (clr_vld && clr_num == 4'(i))) d[i] = 1'b0;
      else d[i] = q[i];
    end
    return d & IMPL;
  endfunction

  function automatic logic [11:0] gmask_of(logic m, logic s, logic u);
    return ({12{m}} & M_G) | ({12{s}} & S_G) | ({12{u}} & U_G);
  endfunction

  function automatic logic [36:0] expect_out(logic [11:0] live);
    logic [3:0] c;
    c = 0;
    for (int i = 11; i >= 0; i--) if (live[i]) c = 4'(i);
    if (live == 0) return '0;
    return {1'b1, c, 32'h8000_0000 | 32'(c)};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are set while clk is low; outputs are compared at the next falling edge.
  task automatic step(string tag);
    logic [36:0] eo;
    m_pend = nxt_pend(m_pend);
    if (en_we) m_en = en_wdata & IMPL;
    eo = expect_out(m_pend & m_en & gmask_of(gie_m, gie_s, gie_u));
    @(posedge clk);
    @(negedge clk);
    check({tag, " pend"}, 64'(pend_rdata), 64'(m_pend));
    check({tag, " en"}, 64'(en_rdata), 64'(m_en));
    check({tag, " out"}, 64'({irq_req, irq_code, irq_cause}), 64'(eo));
    post_vld = 0; clr_vld = 0; clr_all = 0; pend_we = 0; en_we = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 pend", 64'(pend_rdata), 0);
    check("R1 en", 64'(en_rdata), 0);
    check("R1 out", 64'({irq_req, irq_code, irq_cause}), 0);
    rst = 0;
    @(negedge clk);
    check("R1 after release", 64'({irq_req, irq_code, irq_cause, pend_rdata}), 0);

    // R4 write enable vector, R5 reserved bits dropped
    en_we = 1; en_wdata = 12'hFFF; step("R4 R5 en write");
    // R2 post with no global enable: no request (R7)
    post_vld = 1; post_num = 4'd7; step("R2 post");
    // R6 machine group unmasks code 7, R10 single-edge latency
    gie_m = 1; step("R6 R10 gie_m");
    // R8 lower code 3 wins
    post_vld = 1; post_num = 4'd3; step("R8 lowest");
    // R6 user code 0 masked until gie_u
    post_vld = 1; post_num = 4'd0; step("R6 user masked");
    gie_u = 1; step("R6 R9 user unmasked");
    // R5 reserved and out-of-range posts
    post_vld = 1; post_num = 4'd2; step("R5 rsvd post");
    post_vld = 1; post_num = 4'd14; step("R5 oob post");
    pend_we = 1; pend_wdata = 12'h444; step("R5 rsvd write");
    // R3 post beats clear on same bit
    post_vld = 1; post_num = 4'd5; clr_vld = 1; clr_num = 4'd5; step("R3 post vs clr");
    post_vld = 1; post_num = 4'd9; clr_all = 1; step("R3 post vs clr_all");
    // R3 write beats post
    pend_we = 1; pend_wdata = 12'h000; post_vld = 1; post_num = 4'd9; step("R3 write vs post");
    // R2 clear and clear-all leave enables
    pend_we = 1; pend_wdata = 12'hBBB; step("R4 pend write");
    clr_vld = 1; clr_num = 4'd0; step("R2 clear");
    clr_all = 1; step("R2 clr_all");
    gie_s = 1; post_vld = 1; post_num = 4'd11; step("R9 code 11");

    // random mix
    for (int k = 0; k < 400; k++) begin
      post_vld = 1'($urandom); post_num = 4'($urandom);
      clr_vld = 1'($urandom); clr_num = 4'($urandom);
      clr_all = ($urandom % 8) == 0;
      pend_we = ($urandom % 6) == 0; pend_wdata = 12'($urandom);
      en_we = ($urandom % 5) == 0; en_wdata = 12'($urandom);
      gie_m = 1'($urandom); gie_s = 1'($urandom); gie_u = 1'($urandom);
      step("R2 R3 R7 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule